// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This controller brings up a set of supply rails (five by default) in a fixed order. When the operator switch is turned on, it enables rail 0 first. It then waits for that rail's power-good input before it enables the next rail. When the last rail reports good, a green indicator lights.

Turning the switch off takes the rails down one at a time in the opposite order. Once the lowest rail is down, the controller asserts a clamp output that ties the supply outputs to ground.

Any supply problem stops the rails at once. This covers a rail that never reports good within a programmable number of cycles, and a rail that loses power-good while it should be up. All enables are removed in the same cycle, the clamp engages and a red indicator lights. The red indicator stays on until the debounced switch is seen off, so the switch must be cycled to restart.

The switch passes through a two-stage synchroniser and a debounce counter before the state machine acts on it.

Top module: `power_rail_sequencer`

## Requirements
- R1: After reset, `rail_en` is all zero, `clamp_on` is 1, and `led_on` and `led_err` are 0.
- R2: Power-up enables rails strictly from bit 0 upward, one rail per step. The next rail is enabled only after `pgood` of the current rail is seen high, so `rail_en` is always a run of ones starting at bit 0.
- R3: `led_on` rises in the cycle after `pgood` of the highest rail is seen during power-up. While `led_on` is 1, every bit of `rail_en` is 1.
- R4: When the debounced switch goes off from the fully-on state, the highest rail is dropped in that cycle. Each further step waits until the dropped rail's `pgood` is low, or until `timeout_cycles` has elapsed (this is not a fault), and then drops the next lower rail. After rail 0 finishes, `clamp_on` rises.
- R5: `clamp_on` is 1 exactly in the off and fault states, and `rail_en` is zero whenever `clamp_on` is 1.
- R6: During power-up, if the current rail's `pgood` stays low for more than `timeout_cycles` cycles, a fault is taken. In that cycle `rail_en` becomes zero, `clamp_on` becomes 1 and `led_err` becomes 1.
- R7: While `led_on` is 1, `pgood` going low on any rail causes a fault. All enables drop in one cycle, `led_on` falls and `led_err` rises in that same cycle.
- R8: During power-up, `pgood` going low on a rail that has already reported good causes a fault.
- R9: A fault holds while the switch stays on. It clears to the off state (`led_err` 0, `clamp_on` 1) only when the debounced switch is low. A later switch-on restarts power-up.
- R10: `led_on` and `led_err` are never 1 together.
- R11: A change of `switch_in` takes effect only after it has held steady for `DEB_CYCLES` consecutive synchronised samples. Pulses shorter than that do not change any output.
- R12: If the switch goes off during power-up, power-down starts by dropping the highest enabled rail and continues downward as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| switch_in | input | 1 | Operator on/off switch, asynchronous |
| pgood | input | RAILS | Power-good per rail, bit 0 is first in the power-up order |
| timeout_cycles | input | TMR_W | Step timeout in clock cycles |
| rail_en | output | RAILS | Regulator enable per rail |
| clamp_on | output | 1 | Ground clamp for the supply outputs |
| led_on | output | 1 | Green indicator, all rails up |
| led_err | output | 1 | Red indicator, latched fault |

## Verification
The assertions take `timeout_cycles` as held stable over a run. They also assume that `pgood` of a rail only acts as a response to that rail's enable, so that a drop seen during power-down is an ordinary ramp-down and not a fault. The stimulus keeps within this in two ways. A rail model raises each `pgood` a fixed two cycles after its enable and lowers it two cycles after release. Failures are injected only as explicit stuck-low, stuck-high or forced-drop masks, which the bench applies while the switch is held steady.

// File: rtl/power_rail_sequencer.sv
module power_rail_sequencer #(
  parameter int RAILS      = 5,
  parameter int TMR_W      = 16,
  parameter int DEB_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             switch_in,
  input  logic [RAILS-1:0] pgood,
  input  logic [TMR_W-1:0] timeout_cycles,
  output logic [RAILS-1:0] rail_en,
  output logic             clamp_on,
  output logic             led_on,
  output logic             led_err
);
  localparam int IDX_W = (RAILS > 1) ? $clog2(RAILS) : 1;
  localparam int DEB_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RAILS - 1);

  typedef enum logic [2:0] {S_OFF, S_UP, S_ON, S_DOWN, S_FAULT} state_t;

  state_t           state;
  logic [1:0]       sw_sync;
  logic             sw_stable;
  logic [DEB_W-1:0] deb_cnt;
  logic [IDX_W-1:0] idx;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sw_sync <= '0;
    else        sw_sync <= {sw_sync[0], switch_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_stable <= 1'b0;
      deb_cnt   <= '0;
    end else if (sw_sync[1] == sw_stable) begin
      deb_cnt <= '0;
    end else if (deb_cnt == DEB_W'(DEB_CYCLES - 1)) begin
      sw_stable <= sw_sync[1];
      deb_cnt   <= '0;
    end else begin
      deb_cnt <= deb_cnt + 1'b1;
    end

  logic [RAILS-1:0] below;
  logic [IDX_W-1:0] idx_up, idx_dn;
  logic             lower_bad, timed_out;

  assign below     = (RAILS'(1) << idx) - RAILS'(1);
  assign lower_bad = |(~pgood & below);
  assign timed_out = (tmr >= timeout_cycles);
  assign idx_up    = idx + 1'b1;
  assign idx_dn    = idx - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_OFF;
      rail_en <= '0;
      idx     <= '0;
      tmr     <= '0;
    end else begin
      if (tmr != '1) tmr <= tmr + 1'b1;
      case (state)
        S_OFF: begin
          rail_en <= '0;
          if (sw_stable) begin
            state   <= S_UP;
            idx     <= '0;
            tmr     <= '0;
            rail_en <= RAILS'(1);
          end
        end
        S_UP: begin
          if (lower_bad || (!pgood[idx] && timed_out)) begin
            state   <= S_FAULT;
            rail_en <= '0;
          end else if (!sw_stable) begin
            state        <= S_DOWN;
            rail_en[idx] <= 1'b0;
            tmr          <= '0;
          end else if (pgood[idx]) begin
            if (idx == LAST) begin
              state <= S_ON;
            end else begin
              idx             <= idx_up;
              rail_en[idx_up] <= 1'b1;
              tmr             <= '0;
            end
          end
        end
        S_ON: begin
          if (~pgood != '0) begin
            state   <= S_FAULT;
            rail_en <= '0;
          end else if (!sw_stable) begin
            state         <= S_DOWN;
            idx           <= LAST;
            rail_en[LAST] <= 1'b0;
            tmr           <= '0;
          end
        end
        S_DOWN: begin
          if (!pgood[idx] || timed_out) begin
            if (idx == '0) begin
              state <= S_OFF;
            end else begin
              idx             <= idx_dn;
              rail_en[idx_dn] <= 1'b0;
              tmr             <= '0;
            end
          end
        end
        S_FAULT: begin
          rail_en <= '0;
          if (!sw_stable) state <= S_OFF;
        end
        default: begin
          state   <= S_OFF;
          rail_en <= '0;
        end
      endcase
    end

  assign clamp_on = (state == S_OFF) || (state == S_FAULT);
  assign led_on   = (state == S_ON);
  assign led_err  = (state == S_FAULT);

endmodule

// File: rtl/power_rail_sequencer_chk.sv
module power_rail_sequencer_chk #(
  parameter int RAILS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RAILS-1:0] rail_en,
  input logic             clamp_on,
  input logic             led_on,
  input logic             led_err,
  input logic             sw_stable
);
  assert_leds_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_on && led_err));

  assert_rail_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & (rail_en + RAILS'(1))) == '0);

  assert_one_rail_per_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en) <= $countones($past(rail_en)) + 1);

  assert_clamp_rails_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_on |-> (rail_en == '0));

  assert_green_all_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |-> (&rail_en));

  assert_fault_clamps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_err) |-> (clamp_on && !led_on));

  assert_fault_needs_switch_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led_err) |-> !sw_stable);
endmodule

bind power_rail_sequencer power_rail_sequencer_chk #(.RAILS(RAILS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .clamp_on(clamp_on),
  .led_on(led_on), .led_err(led_err), .sw_stable(sw_stable));

// File: tb/test_power_rail_sequencer.sv
module test_power_rail_sequencer;
  localparam int RAILS = 5;
  localparam logic [7:0] T_OFF = 8'b00000_100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 1'b0;
  logic [15:0] tmo = 16'd20;
  logic [RAILS-1:0] pgood, rail_en;
  logic clamp_on, led_on, led_err;
  logic [RAILS-1:0] d1 = '0, d2 = '0;
  logic [RAILS-1:0] stuck_lo = '0, stuck_hi = '0, drop = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] prev = T_OFF;

  always #5 clk = ~clk;

  power_rail_sequencer i_power_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .switch_in(sw), .pgood(pgood),
    .timeout_cycles(tmo), .rail_en(rail_en), .clamp_on(clamp_on),
    .led_on(led_on), .led_err(led_err));

  always @(negedge clk) begin
    d1 <= rail_en;
    d2 <= d1;
  end
  assign pgood = (d2 | stuck_hi) & ~stuck_lo & ~drop;

  function automatic logic [7:0] tuple();
    return {rail_en, clamp_on, led_on, led_err};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tuple() !== prev) begin
      if (exp_q.size() == 0) begin
        check(tuple(), prev, "unexpected output change");
      end else begin
        check(tuple(), exp_q.pop_front(), tag_q.pop_front());
      end
      if (led_on && led_err) check({7'd0, 1'b1}, 8'd0, "R10");
      prev = tuple();
    end
  end

  task automatic expect_t(input logic [RAILS-1:0] en, input logic c, input logic g,
                          input logic r, input string req);
    exp_q.push_back({en, c, g, r});
    tag_q.push_back(req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_sw(input logic v);
    @(negedge clk);
    sw = v;
  endtask

  task automatic push_up(input string req);
    expect_t(5'b00001, 0, 0, 0, req);
    expect_t(5'b00011, 0, 0, 0, req);
    expect_t(5'b00111, 0, 0, 0, req);
    expect_t(5'b01111, 0, 0, 0, req);
    expect_t(5'b11111, 0, 0, 0, req);
    expect_t(5'b11111, 0, 1, 0, "R3");
  endtask

  task automatic push_down_from(input int top, input string req);
    for (int i = top; i >= 0; i--) begin
      logic [RAILS-1:0] m;
      m = RAILS'((1 << i) - 1);
      expect_t(m, 0, 0, 0, req);
    end
    expect_t('0, 1, 0, 0, "R5");
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1..all) actual=hung expected=completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tuple(), T_OFF, "R1 reset state");

    // R11: short pulse ignored in off state
    set_sw(1); set_sw(1); set_sw(0);
    repeat (30) @(negedge clk);
    check(tuple(), T_OFF, "R11 short on-pulse ignored");

    // R2/R3 normal power-up
    push_up("R2");
    set_sw(1);
    drain();

    // R11: short off-glitch while on ignored
    set_sw(0); set_sw(1);
    repeat (30) @(negedge clk);
    check(tuple(), {5'b11111, 3'b010}, "R11 short off-pulse ignored");

    // R4 normal power-down
    push_down_from(4, "R4");
    set_sw(0);
    drain();

    // R6 timeout fault
    stuck_lo = 5'b00100;
    expect_t(5'b00001, 0, 0, 0, "R2");
    expect_t(5'b00011, 0, 0, 0, "R2");
    expect_t(5'b00111, 0, 0, 0, "R2");
    expect_t('0, 1, 0, 1, "R6");
    set_sw(1);
    drain();
    repeat (60) @(negedge clk);
    check(tuple(), 8'b00000_101, "R9 fault held while switch on");
    expect_t('0, 1, 0, 0, "R9");
    set_sw(0);
    drain();
    stuck_lo = '0;

    // R9 restart, then R7 drop while on
    push_up("R9 restart");
    set_sw(1);
    drain();
    expect_t('0, 1, 0, 1, "R7");
    @(negedge clk); drop = 5'b00010;
    drain();
    expect_t('0, 1, 0, 0, "R9");
    set_sw(0);
    drain();
    drop = '0;

    // R12 release mid power-up
    tmo = 16'd200;
    stuck_lo = 5'b01000;
    expect_t(5'b00001, 0, 0, 0, "R2");
    expect_t(5'b00011, 0, 0, 0, "R2");
    expect_t(5'b00111, 0, 0, 0, "R2");
    expect_t(5'b01111, 0, 0, 0, "R2");
    set_sw(1);
    drain();
    push_down_from(3, "R12");
    set_sw(0);
    drain();

    // R8 earlier rail lost during power-up
    expect_t(5'b00001, 0, 0, 0, "R2");
    expect_t(5'b00011, 0, 0, 0, "R2");
    expect_t(5'b00111, 0, 0, 0, "R2");
    expect_t(5'b01111, 0, 0, 0, "R2");
    set_sw(1);
    drain();
    expect_t('0, 1, 0, 1, "R8");
    @(negedge clk); drop = 5'b00001;
    drain();
    expect_t('0, 1, 0, 0, "R9");
    set_sw(0);
    drain();
    drop = '0;
    stuck_lo = '0;

    // R4 down step that only ends by timeout
    tmo = 16'd20;
    push_up("R2");
    set_sw(1);
    drain();
    stuck_hi = 5'b10000;
    push_down_from(4, "R4 timeout step");
    set_sw(0);
    drain();
    stuck_hi = '0;

    check({7'd0, exp_q.size() == 0}, 8'd1, "R4 all expected events seen");
    report();
  end
endmodule